// File: doc/BRIEF.md
# Bit-Addressable General-Purpose I/O Port

This block is a 16-pin general-purpose I/O port. Each pin is set as an input or an output on its own through a direction register. One output latch supplies the drive value for output pins. Software can change any group of latch bits in one write, without reading the latch first, by writing ones to a bit-set register or to a bit-clear register.

The same latch also holds a compare pattern for the pins set as inputs. Input pins pass through a two-flop synchronizer. When every input pin matches its latch bit, the block raises a one-cycle match event. The event fires only on the cycle in which the condition turns true.

Registers are reached through a two-bit port offset with read and write strobes and a 16-bit data bus. Pad electronics and interrupt routing sit outside the block.

Top module: `gpio_bitport`

## Requirements
- R1: After reset the direction register and the latch are zero, `pin_oe_o` and `pin_o` are zero, and `match_o` is low.
- R2: A write at offset 1 loads the direction register. A direction bit of 1 makes that pin an output and 0 makes it an input. `pin_oe_o` equals the direction register. A read at offset 1 returns the direction register.
- R3: A write at offset 0 replaces the whole latch with the written word. `pin_o` always equals the latch.
- R4: A write at offset 2 sets the latch bits where the written word is 1. Every other latch bit keeps its value.
- R5: A write at offset 3 clears the latch bits where the written word is 1. Every other latch bit keeps its value.
- R6: A read at offset 0 returns the latch bit for each output pin and the synchronized pin level for each input pin. Reads at offsets 2 and 3 return zero.
- R7: Input pins pass through two flops before any use. A read captured on the first clock edge after a pin change still returns the old level. A read three edges after the change returns the new level.
- R8: `match_o` is a one-cycle pulse. It goes high on the third clock edge after the input pins come to equal their latch bits. It goes low again on the next edge and stays low while the condition holds. It pulses again only after the condition has gone false and then true again.
- R9: Pins set as outputs take no part in the match. Changing their `pin_i` level neither causes nor breaks a match.
- R10: `rdata_o` is registered. It updates on the clock edge where `rd_i` is high and holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 2 | Register offset: 0 latch, 1 direction, 2 set, 3 clear |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| pin_i | input | 16 | Pin levels from the pads |
| pin_o | output | 16 | Drive values (the latch) |
| pin_oe_o | output | 16 | Output enables (the direction register) |
| match_o | output | 1 | One-cycle pattern-match event |

## Verification
The hardest case to reach from the ports is a match edge. The input pins must first differ from the latch and then become equal to it, and the pulse has to be seen in exactly the right cycle. Pulses that fire when they should not must also be caught. The bench sets up a pattern with a known mismatch and then drives the pins to that pattern. It samples `match_o` on the third and fourth edges after the change, and it counts every pulse that occurs.

Two more cases need care. To test that output pins are ignored, the bench toggles the `pin_i` levels of output pins while holding a match and confirms that no extra pulse occurs. Random write sequences on all four offsets, followed by readback, cover how set, clear and direction writes interact.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    OFS_LATCH = 2'd0,
    OFS_DIR   = 2'd1,
    OFS_SET   = 2'd2,
    OFS_CLR   = 2'd3
  } gpio_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      latch_o,
  output logic [W-1:0]      dir_o
);
  logic [W-1:0] latch_q, dir_q, latch_d;

  always_comb begin
    latch_d = latch_q;
    if (wr_i) begin
      unique case (gpio_ofs_e'(addr_i))
        OFS_LATCH: latch_d = wdata_i;
        OFS_SET:   latch_d = latch_q | wdata_i;
        OFS_CLR:   latch_d = latch_q & ~wdata_i;
        default:   latch_d = latch_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      latch_q <= latch_d;
      if (wr_i && addr_i == OFS_DIR) dir_q <= wdata_i;
    end
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;

  assert_set_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_SET) |=>
      ((latch_q & $past(wdata_i)) == $past(wdata_i)) &&
      ((latch_q & ~$past(wdata_i)) == ($past(latch_q) & ~$past(wdata_i))));

  assert_clr_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_CLR) |=>
      ((latch_q & $past(wdata_i)) == '0) &&
      ((latch_q & ~$past(wdata_i)) == ($past(latch_q) & ~$past(wdata_i))));

  assert_dir_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == OFS_DIR) |=> $stable(dir_q));

  assert_latch_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(latch_q));
endmodule

// File: rtl/gpio_match.sv
module gpio_match #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_sync_i,
  input  logic [W-1:0] latch_i,
  input  logic [W-1:0] dir_i,
  output logic         match_o
);
  logic hit, hit_q, pulse_q;

  // output-direction bits are masked out of the compare
  assign hit = (((pins_sync_i ^ latch_i) & ~dir_i) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b1;  // no event for the condition already true at reset
      pulse_q <= 1'b0;
    end else begin
      hit_q   <= hit;
      pulse_q <= hit & ~hit_q;
    end
  end

  assign match_o = pulse_q;

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);

  assert_pulse_needs_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_q) |-> $past(hit));
endmodule

// File: rtl/gpio_bitport.sv
module gpio_bitport
  import gpio_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe_o,
  output logic              match_o
);
  logic [W-1:0] pins_sync, latch, dir, rd_mux, rdata_q;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pins_sync)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .latch_o(latch), .dir_o(dir)
  );

  gpio_match #(.W(W)) u_match (
    .clk_i, .rst_ni, .pins_sync_i(pins_sync), .latch_i(latch), .dir_i(dir),
    .match_o
  );

  always_comb begin
    unique case (gpio_ofs_e'(addr_i))
      OFS_LATCH: rd_mux = (latch & dir) | (pins_sync & ~dir);
      OFS_DIR:   rd_mux = dir;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o  = rdata_q;
  assign pin_o    = latch;
  assign pin_oe_o = dir;

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  assert_oe_tracks_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_DIR) |=> pin_oe_o == $past(wdata_i));
endmodule

// File: tb/tb_gpio_bitport.sv
module tb_gpio_bitport;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr = 0, rd = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0, pins = 0;
  logic [15:0] rdata, pin_out, pin_oe;
  logic        match;

  int errors = 0, checks = 0, pulses = 0;
  logic [15:0] m_latch = 0, m_dir = 0;

  always #2.5 clk = ~clk;

  gpio_bitport dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .match_o(match)
  );

  always @(negedge clk) if (rst_n && match) pulses++;

  function automatic logic [15:0] exp_read0(logic [15:0] l, logic [15:0] d, logic [15:0] p);
    return (l & d) | (p & ~d);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [15:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
    case (a)
      2'd0: m_latch = d;
      2'd1: m_dir = d;
      2'd2: m_latch = m_latch | d;
      default: m_latch = m_latch & ~d;
    endcase
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [15:0] v);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; v = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int p0;
    void'($urandom(32'h5eed_0421));
    idle(3); rst_n = 1; idle(2);

    // R1 reset state
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_o", pin_out, 0);
    chk("R1 match", match, 0);
    chk("R1 pulses", pulses, 0);

    // R2 direction
    wr_reg(1, 16'hF00F);
    chk("R2 oe", pin_oe, 16'hF00F);
    rd_reg(1, v); chk("R2 readback", v, 16'hF00F);

    // R3 latch write
    wr_reg(0, 16'h1234);
    chk("R3 pin_o", pin_out, 16'h1234);

    // R4 / R5
    wr_reg(2, 16'h8001); chk("R4 set", pin_out, 16'h9235);
    wr_reg(3, 16'h1204); chk("R5 clear", pin_out, 16'h8031);
    wr_reg(3, 16'h0000); chk("R5 clear zero", pin_out, 16'h8031);

    // R6 mixed read and zero offsets
    pins = 16'hAAAA; idle(4);
    rd_reg(0, v); chk("R6 read0", v, exp_read0(m_latch, m_dir, pins));
    rd_reg(2, v); chk("R6 read2", v, 0);
    rd_reg(3, v); chk("R6 read3", v, 0);

    // R10 hold without rd
    rd_reg(1, v);
    pins = 16'h5555; idle(4);
    chk("R10 hold", rdata, 16'hF00F);

    // R7 sync latency
    wr_reg(1, 16'h0000);
    pins = 16'h0000; idle(4);
    @(negedge clk); pins = 16'hFFFF; rd = 1; addr = 0;
    @(negedge clk); rd = 0; chk("R7 old level", rdata, 16'h0000);
    idle(1);
    rd_reg(0, v); chk("R7 new level", v, 16'hFFFF);

    // R8 match pulse timing
    wr_reg(0, 16'hA5A5); idle(3);
    p0 = pulses;
    @(negedge clk); pins = 16'hA5A5;
    @(negedge clk); chk("R8 edge1", match, 0);
    @(negedge clk); chk("R8 edge2", match, 0);
    @(negedge clk); chk("R8 edge3", match, 1);
    @(negedge clk); chk("R8 edge4", match, 0);
    idle(5); chk("R8 one pulse", pulses - p0, 1);
    pins = 16'hA5A4; idle(4);
    pins = 16'hA5A5; idle(4);
    chk("R8 repulse", pulses - p0, 2);

    // R9 output pins ignored
    wr_reg(1, 16'h00FF); idle(3);
    p0 = pulses;
    pins = 16'hA55A; idle(5);
    chk("R9 no break", pulses - p0, 0);
    pins = 16'hA500; idle(5);
    chk("R9 no event", pulses - p0, 0);
    pins = 16'h0000; idle(5);
    pins = 16'hA5FF; idle(5);
    chk("R9 input-only match", pulses - p0, 1);

    // random mix R2..R6
    for (int it = 0; it < 300; it++) begin
      logic [1:0] a;
      a = 2'($urandom_range(0, 3));
      wr_reg(a, 16'($urandom));
      if ($urandom_range(0, 1) == 1) pins = 16'($urandom);
      idle(3);
      chk("R3 rand pin_o", pin_out, m_latch);
      chk("R2 rand oe", pin_oe, m_dir);
      rd_reg(0, v); chk("R6 rand read0", v, exp_read0(m_latch, m_dir, pins));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule